// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches three external interrupt pins and turns their activity into per-source interrupt requests for a small processor core. Pins 0 and 1 are synchronous. Each is brought into the system clock domain through a short flop chain and then compared with its previous sample. A two-bit sense code per pin selects low-level, any-change, falling-edge or rising-edge triggering.

Pin 2 is edge-only and has a single polarity bit. Its edge is caught by a flop clocked by the pin itself, so it needs no running system clock. The captured event is then synchronized into the clock domain. The capture clock is the pin combined with the polarity bit, so flipping the polarity while the pin is steady can itself look like an edge and set the flag.

Edge events latch into flags. A flag is cleared by writing a one to it through the register port, or by pulsing the matching acknowledge input. Flags latch whether or not the source is enabled. A request reaches the core only when the source's enable bit and the global interrupt-enable input are both high. The block samples the pin no matter what drives it, so activity caused by the device itself also triggers it.

Top module: `xirq_ctrl`

## Requirements
- R1: With sense code 00 (low level), the pin's request is high exactly while the synchronized pin is low. No flag is latched, so its bit in the flag register reads 0.
- R2: With sense code 01 (any change), both a falling and a rising transition of the pin set its flag.
- R3: With sense code 10 (falling edge), a high-to-low transition sets the flag and a low-to-high transition does not.
- R4: With sense code 11 (rising edge), a low-to-high transition sets the flag and a high-to-low transition does not.
- R5: A low pulse on a synchronous pin that is longer than one clock period sets the flag in falling-edge mode. The request is visible after the third rising clock edge that follows the pin change.
- R6: On pin 2, polarity 0 triggers on falling edges and polarity 1 on rising edges. The edge is captured without the clock, so a glitch that falls between two clock edges still sets the flag.
- R7: With pin 2 held high, changing its polarity bit from 0 to 1 sets its flag.
- R8: Writing to the flag register (address 2) clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R9: A one on ack_i[k] for one cycle clears the flag of source k.
- R10: irq_o[k] = (pending event of source k) AND (enable k) AND gie_i. A flag set while its source is disabled raises the request as soon as the source is enabled.
- R11: Register map and reset state:
  - Address 0 holds the enables: bit 7 for pin 1, bit 6 for pin 0, bit 5 for pin 2.
  - Address 1 holds the sense codes in bits [1:0] for pin 0 and [3:2] for pin 1, and the pin 2 polarity in bit 4.
  - Address 2 holds the flags at the same bit positions as the enables.
  - All fields reset to 0, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sync_i | input | 2 | Synchronous interrupt pins 0 and 1 (idle high) |
| pin_async_i | input | 1 | Asynchronously captured interrupt pin 2 |
| gie_i | input | 1 | Global interrupt enable from the core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 enables, 1 sense, 2 flags) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the addressed register |
| ack_i | input | 3 | Per-source acknowledge, clears the flag |
| irq_o | output | 3 | Per-source interrupt request |

## Verification
A wrong synchronizer or previous-sample stage shows up as a flag that sets on the wrong transition, or one cycle early or late. The bench therefore samples irq_o after exactly the third clock edge following a pin change. A stale or stuck flag appears on the next read of the flag register and keeps irq_o high after a write-one-to-clear or an acknowledge, and the bench looks for it in the cycle right after the clear. A capture flop on pin 2 that is never released, or that misses the polarity transition, becomes visible about four clock cycles later: either no further flags arrive, or the expected spurious flag is absent.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int N_SYNC        = 2;
    localparam int N_SRC         = N_SYNC + 1;
    localparam int ASYNC_IDX     = N_SYNC;
    localparam int REG_W         = 8;
    localparam int ADDR_W        = 2;
    localparam int SENSE_W       = 2;
    localparam int SENSE_POL_BIT = SENSE_W * N_SYNC;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_SENSE = 2'd1,
        REG_FLAG  = 2'd2,
        REG_RSVD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [N_SRC-1:0]                en;
        logic [N_SYNC-1:0][SENSE_W-1:0] code;
        logic                            pol;
    } cfg_t;

    // Bit position of a source in the enable and flag registers
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction

    // Edge qualification between the previous and current synchronized sample
    function automatic logic sense_hit(input sense_e m, input logic prev, input logic cur);
        case (m)
            SENSE_ANY:  return prev ^ cur;
            SENSE_FALL: return prev & ~cur;
            SENSE_RISE: return ~prev & cur;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xirq_sync_src.sv
module xirq_sync_src
    import xirq_pkg::*;
#(
    parameter logic IDLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] mode_i,
    input  logic               clr_i,
    output logic               flag_o,
    output logic               low_o
);

    logic   s1_q, s2_q, s3_q;
    logic   flag_q;
    logic   hit;
    sense_e mode;

    assign mode = sense_e'(mode_i);

    // Two synchronizer stages, the third holds the previous sample
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= IDLE;
            s2_q <= IDLE;
            s3_q <= IDLE;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign hit = sense_hit(mode, s3_q, s2_q);

    // A new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign low_o  = ~s2_q;

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (mode != SENSE_LOW && s2_q != s3_q && (mode == SENSE_ANY || s2_q == mode[0])) |=> flag_q); // R2

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW && !flag_q) |=> !flag_q); // R1

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && s2_q == s3_q) |=> !flag_q); // R8

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && s2_q == s3_q) |=> $stable(flag_q)); // R8

endmodule

// File: rtl/xirq_async_src.sv
module xirq_async_src (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic flag_o
);

    logic edge_clk;
    logic cap_q;
    logic cap_clr;
    logic s1_q, s2_q, s3_q;
    logic flag_q;
    logic set_evt;

    // Polarity 1: pin as clock; polarity 0: inverted pin as clock
    assign edge_clk = ~(pin_i ^ pol_i);
    assign cap_clr  = rst | s2_q;

    always_ff @(posedge edge_clk or posedge cap_clr) begin
        if (cap_clr)
            cap_q <= 1'b0;
        else
            cap_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= cap_q;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign set_evt = s2_q & ~s3_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_ASYNC_SETS: assert property (@(posedge clk) disable iff (rst)
        (s2_q && !s3_q) |=> flag_q); // R6

    AST_ASYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(s2_q && !s3_q)) |=> !flag_q); // R9

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [N_SRC-1:0]  flags_i,
    input  logic [N_SRC-1:0]  ack_i,
    output cfg_t              cfg_o,
    output logic [N_SRC-1:0]  clr_o
);

    cfg_t      cfg_q;
    reg_addr_e addr;

    assign addr = reg_addr_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            case (addr)
                REG_CTRL: begin
                    for (int k = 0; k < N_SRC; k++)
                        cfg_q.en[k] <= wdata_i[src_bit(k)];
                end
                REG_SENSE: begin
                    for (int i = 0; i < N_SYNC; i++)
                        cfg_q.code[i] <= wdata_i[SENSE_W*i +: SENSE_W];
                    cfg_q.pol <= wdata_i[SENSE_POL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int k = 0; k < N_SRC; k++)
            clr_o[k] = ack_i[k] | (wr_i && addr == REG_FLAG && wdata_i[src_bit(k)]);
    end

    always_comb begin
        rdata_o = '0;
        case (addr)
            REG_CTRL: begin
                for (int k = 0; k < N_SRC; k++)
                    rdata_o[src_bit(k)] = cfg_q.en[k];
            end
            REG_SENSE: begin
                for (int i = 0; i < N_SYNC; i++)
                    rdata_o[SENSE_W*i +: SENSE_W] = cfg_q.code[i];
                rdata_o[SENSE_POL_BIT] = cfg_q.pol;
            end
            REG_FLAG: begin
                for (int k = 0; k < N_SRC; k++)
                    rdata_o[src_bit(k)] = flags_i[k];
            end
            default: ;
        endcase
    end

    assign cfg_o = cfg_q;

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && addr_i == REG_CTRL) |=> $stable(cfg_q.en)); // R11

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SYNC-1:0] pin_sync_i,
    input  logic              pin_async_i,
    input  logic              gie_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [N_SRC-1:0]  ack_i,
    output logic [N_SRC-1:0]  irq_o
);

    cfg_t              cfg;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  clr;
    logic [N_SRC-1:0]  pend;
    logic [N_SYNC-1:0] low;

    xirq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .flags_i (flags),
        .ack_i   (ack_i),
        .cfg_o   (cfg),
        .clr_o   (clr)
    );

    for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
        xirq_sync_src #(.IDLE(1'b1)) u_src (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_sync_i[i]),
            .mode_i (cfg.code[i]),
            .clr_i  (clr[i]),
            .flag_o (flags[i]),
            .low_o  (low[i])
        );
        assign pend[i] = (sense_e'(cfg.code[i]) == SENSE_LOW) ? low[i] : flags[i];
    end

    xirq_async_src u_async (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_async_i),
        .pol_i  (cfg.pol),
        .clr_i  (clr[ASYNC_IDX]),
        .flag_o (flags[ASYNC_IDX])
    );
    assign pend[ASYNC_IDX] = flags[ASYNC_IDX];

    assign irq_o = pend & cfg.en & {N_SRC{gie_i}};

endmodule

// File: tb/xirq_ctrl_tb_top.sv
module xirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] pin_s;
    logic       pin_a;
    logic       gie;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [2:0] ack;
    logic [2:0] irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xirq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .pin_sync_i  (pin_s),
        .pin_async_i (pin_a),
        .gie_i       (gie),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ack_i       (ack),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(tag, rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic [2:0] exp);
        #1 chk(tag, {5'b0, irq}, {5'b0, exp});
    endtask

    task automatic t_reset();
        chk_reg("R11 reset enables", 2'd0, 8'h00);
        chk_reg("R11 reset sense", 2'd1, 8'h00);
        chk_reg("R11 reset flags", 2'd2, 8'h00);
        chk_irq("R11 reset irq", 3'b000);
    endtask

    task automatic t_level();
        reg_wr(2'd0, 8'h40);
        chk_reg("R11 enable readback", 2'd0, 8'h40);
        reg_wr(2'd1, 8'h00);
        gie = 1'b1;
        @(negedge clk) pin_s[0] = 1'b0;
        wait_cyc(3);
        chk_irq("R1 level low requests", 3'b001);
        chk_reg("R1 level sets no flag", 2'd2, 8'h00);
        @(negedge clk) pin_s[0] = 1'b1;
        wait_cyc(3);
        chk_irq("R1 level high drops", 3'b000);
    endtask

    task automatic t_fall();
        reg_wr(2'd1, 8'h02);
        @(negedge clk) pin_s[0] = 1'b0;
        wait_cyc(3);
        chk_irq("R3 falling sets", 3'b001);
        chk_reg("R3 flag bit6", 2'd2, 8'h40);
        reg_wr(2'd2, 8'h00);
        chk_reg("R8 zero write keeps flag", 2'd2, 8'h40);
        reg_wr(2'd2, 8'h40);
        chk_irq("R8 w1c clears irq", 3'b000);
        @(negedge clk) pin_s[0] = 1'b1;
        wait_cyc(3);
        chk_irq("R3 rising ignored", 3'b000);
        chk_reg("R3 no flag on rise", 2'd2, 8'h00);
    endtask

    task automatic t_pulse();
        @(negedge clk) pin_s[0] = 1'b0;
        #12 pin_s[0] = 1'b1;
        @(negedge clk);
        wait_cyc(2);
        chk_irq("R5 long pulse caught", 3'b001);
        reg_wr(2'd2, 8'h40);
    endtask

    task automatic t_rise();
        reg_wr(2'd0, 8'h80);
        reg_wr(2'd1, 8'h0C);
        @(negedge clk) pin_s[1] = 1'b0;
        wait_cyc(3);
        chk_irq("R4 falling ignored", 3'b000);
        @(negedge clk) pin_s[1] = 1'b1;
        wait_cyc(3);
        chk_irq("R4 rising sets", 3'b010);
        chk_reg("R4 flag bit7", 2'd2, 8'h80);
        @(negedge clk) ack = 3'b010;
        @(negedge clk) ack = 3'b000;
        chk_irq("R9 ack clears", 3'b000);
        chk_reg("R9 flag gone", 2'd2, 8'h00);
    endtask

    task automatic t_any();
        reg_wr(2'd0, 8'h40);
        reg_wr(2'd1, 8'h01);
        @(negedge clk) pin_s[0] = 1'b0;
        wait_cyc(3);
        chk_irq("R2 any change fall", 3'b001);
        reg_wr(2'd2, 8'h40);
        @(negedge clk) pin_s[0] = 1'b1;
        wait_cyc(3);
        chk_irq("R2 any change rise", 3'b001);
    endtask

    task automatic t_gate();
        @(negedge clk) gie = 1'b0;
        chk_irq("R10 gie low blocks", 3'b000);
        @(negedge clk) gie = 1'b1;
        chk_irq("R10 gie high passes", 3'b001);
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd2, 8'h40);
        @(negedge clk) pin_s[0] = 1'b0;
        wait_cyc(3);
        chk_irq("R10 disabled no irq", 3'b000);
        chk_reg("R10 disabled flag pending", 2'd2, 8'h40);
        reg_wr(2'd0, 8'h40);
        chk_irq("R10 pending fires on enable", 3'b001);
        reg_wr(2'd2, 8'h40);
        @(negedge clk) pin_s[0] = 1'b1;
        wait_cyc(3);
        reg_wr(2'd2, 8'h40);
    endtask

    task automatic t_async();
        reg_wr(2'd0, 8'h20);
        reg_wr(2'd1, 8'h00);
        @(negedge clk) pin_a = 1'b0;
        wait_cyc(5);
        chk_irq("R6 pol0 falling sets", 3'b100);
        chk_reg("R6 flag bit5", 2'd2, 8'h20);
        reg_wr(2'd2, 8'h20);
        chk_irq("R8 async w1c", 3'b000);
        @(negedge clk) pin_a = 1'b1;
        wait_cyc(5);
        chk_irq("R6 pol0 rising ignored", 3'b000);
        reg_wr(2'd1, 8'h10);
        wait_cyc(5);
        chk_reg("R7 polarity change sets flag", 2'd2, 8'h20);
        chk_reg("R11 sense readback", 2'd1, 8'h10);
        reg_wr(2'd2, 8'h20);
        @(negedge clk) pin_a = 1'b0;
        wait_cyc(5);
        chk_irq("R6 pol1 falling ignored", 3'b000);
        @(negedge clk) pin_a = 1'b1;
        wait_cyc(5);
        chk_irq("R6 pol1 rising sets", 3'b100);
        @(negedge clk) ack = 3'b100;
        @(negedge clk) ack = 3'b000;
        chk_irq("R9 async ack", 3'b000);
        @(negedge clk);
        #2 pin_a = 1'b0;
        #2 pin_a = 1'b1;
        wait_cyc(5);
        chk_irq("R6 glitch between edges caught", 3'b100);
    endtask

    initial begin
        rst = 1'b1; pin_s = 2'b11; pin_a = 1'b1; gie = 1'b0;
        wr = 1'b0; addr = 2'd0; wdata = 8'h00; ack = 3'b000;
        wait_cyc(3);
        rst = 1'b0;
        t_reset();
        t_level();
        t_fall();
        t_pulse();
        t_rise();
        t_any();
        t_gate();
        t_async();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule